// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small bank of status flags that tell firmware why the processor core last restarted or woke up. Each reset or wake source delivers a one-cycle event pulse. A two-bit power-mode qualifier tells the block whether the core is in full-power execution, a low-power run mode, idle, or sleep. On every event the block works out a new value for each flag. Each flag is set, cleared or kept according to the cause and, for some causes, the power mode.

For each event the block also computes where execution resumes. A true reset resumes at address zero. A wake-up from a low-power mode resumes at the current program counter plus two, or at an interrupt vector. The block announces the new address with a load strobe, and it raises a core reset request for true resets only. Firmware can write the flag bank through a simple write port, so it can re-arm flags and tell the next cause apart. The write port can never change the watchdog and power-down flags.

All outputs are registered. An event sampled on one rising clock edge becomes visible on the outputs straight after that edge. If several events arrive in the same cycle, a fixed priority picks the single event that decides the update.

Top module: `reset_cause_reg`

## Requirements
- R1: The `flags` bit positions are: bit0 power-on-done, bit1 brownout-done, bit2 power-down, bit3 watchdog-ok, bit4 soft-reset-done, bit5 config-ok, bit6 stack-full, bit7 stack-empty. The synchronous `rst` input and a power-on event both give `flags`=8'h3C. A power-on event also gives `next_pc`=0 and pulses `core_rst`. During `rst`, `pc_load`, `core_rst` and `next_pc` are 0.
- R2: A soft reset event clears bit4 only, loads `next_pc`=0 and requests a core reset.
- R3: A brownout event sets bits 2, 3, 4 and 5, clears bit1, keeps bits 0, 6 and 7, loads 0 and requests a core reset.
- R4: A configuration-mismatch event clears bit5 only, loads 0 and requests a core reset.
- R5: A master-clear event always loads 0 and requests a core reset. Its effect on the flags depends on `pmode` (0 full, 1 run, 2 idle, 3 sleep). In full power it changes no flag. In run it sets bit3. In idle or sleep it sets bit3 and clears bit2.
- R6: With `stk_rst_en`=1, a stack-full event sets bit6, and a stack-underflow event sets bit7. Either event loads 0 and requests a core reset.
- R7: With `stk_rst_en`=0, a stack-underflow event sets bit7 only and raises neither `pc_load` nor `core_rst`. A stack-full event has no effect at all.
- R8: A watchdog event in full-power or run mode clears bit3, loads 0 and requests a core reset.
- R9: A watchdog event in idle or sleep is a wake-up. It clears bits 3 and 2, loads `pc_cur`+2 and requests no reset.
- R10: An interrupt wake event in any mode other than full power clears bit2 and requests no reset. If `gie_hi` or `gie_lo` is set, it loads the vector: 16'h0008 when `irq_hi`=1 and 16'h0018 otherwise. If neither is set, it loads `pc_cur`+2. In full-power mode the event is ignored.
- R11: Simultaneous events are resolved by priority, highest first: power-on, brownout, master-clear, configuration-mismatch, stack (full before underflow), watchdog, soft reset, interrupt wake.
- R12: `sw_we` writes `sw_wdata` into bits 0, 1, 4, 5, 6 and 7 only in cycles with no event. Bits 2 and 3 never change through a write.
- R13: `core_rst` is high for exactly one cycle per true reset and always comes with `pc_load`=1 and `next_pc`=0. `next_pc` holds its value while `pc_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pmode | input | 2 | Power mode: 0 full, 1 run, 2 idle, 3 sleep |
| stk_rst_en | input | 1 | Stack errors cause a reset |
| ev_pon | input | 1 | Power-on event pulse |
| ev_brownout | input | 1 | Brownout event pulse |
| ev_mclr | input | 1 | External master-clear event pulse |
| ev_cfg_err | input | 1 | Configuration-mismatch event pulse |
| ev_stk_full | input | 1 | Stack-full event pulse |
| ev_stk_under | input | 1 | Stack-underflow event pulse |
| ev_wdog | input | 1 | Watchdog timeout event pulse |
| ev_swreset | input | 1 | Soft reset instruction event pulse |
| ev_irq_wake | input | 1 | Interrupt wake event pulse |
| irq_hi | input | 1 | Waking interrupt is high priority |
| gie_hi | input | 1 | High-priority global interrupt enable |
| gie_lo | input | 1 | Low-priority global interrupt enable |
| pc_cur | input | PC_W | Current program counter |
| sw_we | input | 1 | Firmware write strobe |
| sw_wdata | input | 8 | Firmware write data |
| flags | output | 8 | Cause flag bank |
| next_pc | output | PC_W | Resume address |
| pc_load | output | 1 | Resume address valid strobe |
| core_rst | output | 1 | Core reset request pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the priority grant is one-hot;
- a power-on event lands in the fixed reset state;
- the two protected flags hold in cycles with no event;
- every reset request comes with a zero resume address and follows an event;
- an interrupt wake never requests a reset.

Other behaviour needs the reference model in the bench to show it. That covers the per-cause, per-mode set/clear patterns, the PC+2 and vector selection, the stack enable split, and write masking. It also covers which event wins when events collide.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int NFLAG = 8;
  localparam int NSRC  = 9;

  localparam int FB_PON   = 0;
  localparam int FB_BRN   = 1;
  localparam int FB_PWR   = 2;
  localparam int FB_WDOG  = 3;
  localparam int FB_SW    = 4;
  localparam int FB_CFG   = 5;
  localparam int FB_FULL  = 6;
  localparam int FB_EMPTY = 7;

  localparam logic [NFLAG-1:0] PON_FLAGS =
    (NFLAG'(1) << FB_PWR) | (NFLAG'(1) << FB_WDOG) |
    (NFLAG'(1) << FB_SW)  | (NFLAG'(1) << FB_CFG);

  localparam logic [NFLAG-1:0] SW_WMASK =
    ~((NFLAG'(1) << FB_PWR) | (NFLAG'(1) << FB_WDOG));

  typedef enum logic [1:0] {
    PM_FULL  = 2'd0,
    PM_RUN   = 2'd1,
    PM_IDLE  = 2'd2,
    PM_SLEEP = 2'd3
  } pmode_e;

  // order of the non-idle values equals request priority order (index+1)
  typedef enum logic [3:0] {
    CZ_NONE  = 4'd0,
    CZ_PON   = 4'd1,
    CZ_BRN   = 4'd2,
    CZ_MCLR  = 4'd3,
    CZ_CFG   = 4'd4,
    CZ_FULL  = 4'd5,
    CZ_UNDER = 4'd6,
    CZ_WDOG  = 4'd7,
    CZ_SW    = 4'd8,
    CZ_IRQ   = 4'd9
  } cause_e;

  typedef struct packed {
    logic [NFLAG-1:0] set;
    logic [NFLAG-1:0] clr;
  } fmask_t;

endpackage

// File: rtl/rcs_arbiter.sv
module rcs_arbiter
  import rcs_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output cause_e       cause
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pri
      assign seen[i+1] = seen[i] | req[i];
      assign grant[i]  = req[i] & ~seen[i];
    end
  endgenerate

  always_comb begin
    cause = CZ_NONE;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) cause = cause_e'(4'(i + 1));
    end
  end

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_when_req_R11: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (grant != '0));

endmodule

// File: rtl/rcs_flag_rules.sv
module rcs_flag_rules
  import rcs_pkg::*;
(
  input  cause_e      cause,
  input  logic [1:0]  pmode,
  input  logic        stk_en,
  output fmask_t      fm
);

  function automatic logic [NFLAG-1:0] b(input int pos);
    return NFLAG'(1) << pos;
  endfunction

  logic low_sleep;
  assign low_sleep = (pmode == PM_IDLE) || (pmode == PM_SLEEP);

  always_comb begin
    fm.set = '0;
    fm.clr = '0;
    unique case (cause)
      CZ_PON: begin
        fm.set = PON_FLAGS;
        fm.clr = ~PON_FLAGS;
      end
      CZ_BRN: begin
        fm.set = b(FB_PWR) | b(FB_WDOG) | b(FB_SW) | b(FB_CFG);
        fm.clr = b(FB_BRN);
      end
      CZ_MCLR: begin
        if (pmode == PM_RUN) fm.set = b(FB_WDOG);
        else if (low_sleep) begin
          fm.set = b(FB_WDOG);
          fm.clr = b(FB_PWR);
        end
      end
      CZ_CFG:   fm.clr = b(FB_CFG);
      CZ_FULL:  fm.set = stk_en ? b(FB_FULL) : '0;
      CZ_UNDER: fm.set = b(FB_EMPTY);
      CZ_WDOG:  fm.clr = low_sleep ? (b(FB_WDOG) | b(FB_PWR)) : b(FB_WDOG);
      CZ_SW:    fm.clr = b(FB_SW);
      CZ_IRQ:   fm.clr = b(FB_PWR);
      default: begin
        fm.set = '0;
        fm.clr = '0;
      end
    endcase
  end

endmodule

// File: rtl/rcs_pc_rules.sv
module rcs_pc_rules
  import rcs_pkg::*;
#(
  parameter int              PC_W   = 16,
  parameter logic [PC_W-1:0] VEC_HI = PC_W'(16'h0008),
  parameter logic [PC_W-1:0] VEC_LO = PC_W'(16'h0018)
) (
  input  cause_e          cause,
  input  logic [1:0]      pmode,
  input  logic            stk_en,
  input  logic [PC_W-1:0] pc_cur,
  input  logic            irq_hi,
  input  logic            gie_hi,
  input  logic            gie_lo,
  output logic [PC_W-1:0] pc_nxt,
  output logic            load,
  output logic            rst_req
);

  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic low_sleep;
  logic [PC_W-1:0] pc_wake;
  assign low_sleep = (pmode == PM_IDLE) || (pmode == PM_SLEEP);
  assign pc_wake   = pc_cur + STEP;

  always_comb begin
    pc_nxt  = '0;
    load    = 1'b0;
    rst_req = 1'b0;
    unique case (cause)
      CZ_PON, CZ_BRN, CZ_MCLR, CZ_CFG, CZ_SW: begin
        load    = 1'b1;
        rst_req = 1'b1;
      end
      CZ_FULL, CZ_UNDER: begin
        load    = stk_en;
        rst_req = stk_en;
      end
      CZ_WDOG: begin
        load = 1'b1;
        if (low_sleep) pc_nxt = pc_wake;
        else           rst_req = 1'b1;
      end
      CZ_IRQ: begin
        load = 1'b1;
        if (gie_hi || gie_lo) pc_nxt = irq_hi ? VEC_HI : VEC_LO;
        else                  pc_nxt = pc_wake;
      end
      default: begin
        load    = 1'b0;
        rst_req = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcs_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      pmode,
  input  logic            stk_rst_en,
  input  logic            ev_pon,
  input  logic            ev_brownout,
  input  logic            ev_mclr,
  input  logic            ev_cfg_err,
  input  logic            ev_stk_full,
  input  logic            ev_stk_under,
  input  logic            ev_wdog,
  input  logic            ev_swreset,
  input  logic            ev_irq_wake,
  input  logic            irq_hi,
  input  logic            gie_hi,
  input  logic            gie_lo,
  input  logic [PC_W-1:0] pc_cur,
  input  logic            sw_we,
  input  logic [7:0]      sw_wdata,
  output logic [7:0]      flags,
  output logic [PC_W-1:0] next_pc,
  output logic            pc_load,
  output logic            core_rst
);

  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  cause_e          cause;
  fmask_t          fm;
  logic [PC_W-1:0] pc_nxt;
  logic            ld_nxt;
  logic            rr_nxt;
  logic            any_ev;

  // index 0 is the highest priority
  assign req = {
    ev_irq_wake & (pmode != PM_FULL),
    ev_swreset,
    ev_wdog,
    ev_stk_under,
    ev_stk_full & stk_rst_en,
    ev_cfg_err,
    ev_mclr,
    ev_brownout,
    ev_pon
  };

  rcs_arbiter #(.N(NSRC)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .grant (grant),
    .cause (cause)
  );

  rcs_flag_rules u_flags (
    .cause  (cause),
    .pmode  (pmode),
    .stk_en (stk_rst_en),
    .fm     (fm)
  );

  rcs_pc_rules #(.PC_W(PC_W)) u_pc (
    .cause   (cause),
    .pmode   (pmode),
    .stk_en  (stk_rst_en),
    .pc_cur  (pc_cur),
    .irq_hi  (irq_hi),
    .gie_hi  (gie_hi),
    .gie_lo  (gie_lo),
    .pc_nxt  (pc_nxt),
    .load    (ld_nxt),
    .rst_req (rr_nxt)
  );

  assign any_ev = (cause != CZ_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= PON_FLAGS;
      next_pc  <= '0;
      pc_load  <= 1'b0;
      core_rst <= 1'b0;
    end else begin
      pc_load  <= ld_nxt;
      core_rst <= rr_nxt;
      if (ld_nxt) next_pc <= pc_nxt;
      if (any_ev)     flags <= (flags & ~fm.clr) | fm.set;
      else if (sw_we) flags <= (flags & ~SW_WMASK) | (sw_wdata & SW_WMASK);
    end
  end

  assert_pon_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ev_pon) |-> (flags == PON_FLAGS && core_rst && next_pc == '0));

  assert_ro_bits_R12: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !any_ev) |-> ($stable(flags[FB_WDOG]) && $stable(flags[FB_PWR])));

  assert_rst_to_zero_R13: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (pc_load && next_pc == '0));

  assert_rst_needs_event_R13: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> $past(any_ev));

  assert_irq_no_rst_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cause == CZ_IRQ) |-> (!core_rst && pc_load));

endmodule

// File: tb/reset_cause_reg_bench.sv
module reset_cause_reg_bench;

  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rst;
  logic [1:0]      pmode;
  logic            stk_rst_en;
  logic            ev_pon, ev_brownout, ev_mclr, ev_cfg_err, ev_stk_full;
  logic            ev_stk_under, ev_wdog, ev_swreset, ev_irq_wake;
  logic            irq_hi, gie_hi, gie_lo;
  logic [PC_W-1:0] pc_cur;
  logic            sw_we;
  logic [7:0]      sw_wdata;
  logic [7:0]      flags;
  logic [PC_W-1:0] next_pc;
  logic            pc_load;
  logic            core_rst;

  always #4 clk = ~clk;

  reset_cause_reg #(.PC_W(PC_W)) u_reset_cause_reg (
    .clk(clk), .rst(rst), .pmode(pmode), .stk_rst_en(stk_rst_en),
    .ev_pon(ev_pon), .ev_brownout(ev_brownout), .ev_mclr(ev_mclr),
    .ev_cfg_err(ev_cfg_err), .ev_stk_full(ev_stk_full),
    .ev_stk_under(ev_stk_under), .ev_wdog(ev_wdog), .ev_swreset(ev_swreset),
    .ev_irq_wake(ev_irq_wake), .irq_hi(irq_hi), .gie_hi(gie_hi),
    .gie_lo(gie_lo), .pc_cur(pc_cur), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .flags(flags), .next_pc(next_pc), .pc_load(pc_load), .core_rst(core_rst)
  );

  // flag bit meanings as stated in R1
  localparam int B_PON = 0, B_BRN = 1, B_PWR = 2, B_WDOG = 3;
  localparam int B_SW = 4, B_CFG = 5, B_FULL = 6, B_EMPTY = 7;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [7:0]      m_flags;
  logic [PC_W-1:0] m_pc;
  logic            m_load, m_rst;
  string           tag;

  task automatic chk(string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_ev();
    ev_pon = 0; ev_brownout = 0; ev_mclr = 0; ev_cfg_err = 0; ev_stk_full = 0;
    ev_stk_under = 0; ev_wdog = 0; ev_swreset = 0; ev_irq_wake = 0; sw_we = 0;
  endtask

  // behavioural reference: decide the expected post-edge outputs
  task automatic predict();
    int n;
    bit lowp;
    n = ev_pon + ev_brownout + ev_mclr + ev_cfg_err + (ev_stk_full & stk_rst_en)
      + ev_stk_under + ev_wdog + ev_swreset + (ev_irq_wake & (pmode != 0));
    lowp = (pmode >= 2);
    m_load = 0; m_rst = 0;
    if (ev_pon) begin
      tag = "R1"; m_flags = 8'h3C; m_load = 1; m_rst = 1; m_pc = 0;
    end else if (ev_brownout) begin
      tag = "R3";
      m_flags[B_PWR] = 1; m_flags[B_WDOG] = 1; m_flags[B_SW] = 1; m_flags[B_CFG] = 1;
      m_flags[B_BRN] = 0; m_load = 1; m_rst = 1; m_pc = 0;
    end else if (ev_mclr) begin
      tag = "R5";
      if (pmode == 1) m_flags[B_WDOG] = 1;
      if (lowp) begin m_flags[B_WDOG] = 1; m_flags[B_PWR] = 0; end
      m_load = 1; m_rst = 1; m_pc = 0;
    end else if (ev_cfg_err) begin
      tag = "R4"; m_flags[B_CFG] = 0; m_load = 1; m_rst = 1; m_pc = 0;
    end else if (ev_stk_full && stk_rst_en) begin
      tag = "R6"; m_flags[B_FULL] = 1; m_load = 1; m_rst = 1; m_pc = 0;
    end else if (ev_stk_under) begin
      m_flags[B_EMPTY] = 1;
      if (stk_rst_en) begin tag = "R6"; m_load = 1; m_rst = 1; m_pc = 0; end
      else tag = "R7";
    end else if (ev_wdog) begin
      m_flags[B_WDOG] = 0; m_load = 1;
      if (lowp) begin tag = "R9"; m_flags[B_PWR] = 0; m_pc = pc_cur + 16'd2; end
      else begin tag = "R8"; m_rst = 1; m_pc = 0; end
    end else if (ev_swreset) begin
      tag = "R2"; m_flags[B_SW] = 0; m_load = 1; m_rst = 1; m_pc = 0;
    end else if (ev_irq_wake && pmode != 0) begin
      tag = "R10"; m_flags[B_PWR] = 0; m_load = 1;
      if (gie_hi || gie_lo) m_pc = irq_hi ? 16'h0008 : 16'h0018;
      else m_pc = pc_cur + 16'd2;
    end else if (sw_we) begin
      tag = "R12";
      for (int i = 0; i < 8; i++)
        if (i != B_PWR && i != B_WDOG) m_flags[i] = sw_wdata[i];
    end else begin
      tag = (ev_stk_full || ev_irq_wake) ? "R7/R10 ignored" : "R13";
    end
    if (n > 1) tag = {"R11 ", tag};
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    chk("flags", flags, m_flags);
    chk("core_rst", core_rst, m_rst);
    chk("pc_load", pc_load, m_load);
    chk("next_pc", next_pc, m_pc);
    clear_ev();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    clear_ev();
    rst = 1; pmode = 0; stk_rst_en = 1; irq_hi = 0; gie_hi = 0; gie_lo = 0;
    pc_cur = 16'h1230; sw_wdata = 0;
    repeat (2) @(negedge clk);
    tag = "R1 reset";
    chk("flags", flags, 8'h3C); chk("core_rst", core_rst, 0);
    chk("pc_load", pc_load, 0); chk("next_pc", next_pc, 0);
    m_flags = 8'h3C; m_pc = 0;
    rst = 0;
    step();
    // firmware arms all writable bits, tries protected bits (R12)
    sw_we = 1; sw_wdata = 8'hFF; step();
    sw_we = 1; sw_wdata = 8'h00; step();
    sw_we = 1; sw_wdata = 8'hF3; step();
    ev_swreset = 1; step();                                   // R2
    step();                                                   // R13 pulse ends
    ev_brownout = 1; step();                                  // R3
    ev_cfg_err = 1; step();                                   // R4
    for (int m = 0; m < 4; m++) begin                         // R5
      pmode = 2'(m); sw_we = 1; sw_wdata = 8'hFF; step();
      ev_mclr = 1; step();
      ev_wdog = 1; step();                                    // R8 / R9
    end
    pmode = 0; stk_rst_en = 1;
    sw_we = 1; sw_wdata = 8'h00; step();
    ev_stk_full = 1; step();                                  // R6
    ev_stk_under = 1; step();                                 // R6
    stk_rst_en = 0; sw_we = 1; sw_wdata = 8'h00; step();
    ev_stk_full = 1; step();                                  // R7 ignored
    ev_stk_under = 1; step();                                 // R7 no reset
    ev_stk_under = 1; sw_we = 1; sw_wdata = 8'h3F; step();    // R12 write blocked
    pmode = 3; pc_cur = 16'hFFFE; ev_irq_wake = 1; step();   // R10 wrap
    gie_hi = 1; irq_hi = 1; ev_irq_wake = 1; step();          // R10 high vector
    gie_hi = 0; gie_lo = 1; irq_hi = 0; ev_irq_wake = 1; step(); // R10 low vector
    pmode = 0; ev_irq_wake = 1; step();                       // R10 ignored
    pmode = 2; ev_wdog = 1; ev_swreset = 1; ev_irq_wake = 1; step(); // R11
    ev_mclr = 1; ev_cfg_err = 1; ev_brownout = 1; step();     // R11
    ev_pon = 1; ev_brownout = 1; ev_wdog = 1; step();         // R11 / R1
    for (int k = 0; k < 400; k++) begin
      pmode = 2'($urandom_range(0, 3));
      stk_rst_en = 1'($urandom);
      gie_hi = 1'($urandom); gie_lo = 1'($urandom); irq_hi = 1'($urandom);
      pc_cur = 16'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        ev_pon       = ($urandom_range(0, 15) == 0);
        ev_brownout  = ($urandom_range(0, 7) == 0);
        ev_mclr      = ($urandom_range(0, 4) == 0);
        ev_cfg_err   = ($urandom_range(0, 4) == 0);
        ev_stk_full  = ($urandom_range(0, 3) == 0);
        ev_stk_under = ($urandom_range(0, 3) == 0);
        ev_wdog      = ($urandom_range(0, 2) == 0);
        ev_swreset   = ($urandom_range(0, 2) == 0);
        ev_irq_wake  = ($urandom_range(0, 1) == 0);
      end
      sw_we = 1'($urandom); sw_wdata = 8'($urandom);
      step();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule